// File: doc/BRIEF.md
# Wake-Qualifying Receive Path for a Single-Wire Bus

This block sits behind the two level comparators of a single-wire bus transceiver and turns their digitised flags into an active-low receive line and a wake event. One flag reports that the bus is above the ordinary receive level. The other reports that the bus is above the higher wake-up level. Both flags arrive asynchronously. Each is brought into the clock domain by two flip-flops and then cleaned by a short majority vote before it is used.

In the three active modes (normal, high-speed and wake-call), the receive line follows the ordinary-level flag, inverted. High-speed mode adds a blanking window. It opens on each bus falling-edge indication, forces the line recessive, and ignores any ringing until the window closes. In sleep mode, ordinary-level traffic is not reported. A wake-up level is reported only after it has persisted for a dead time, and once reported it stays low for at least a minimum pulse width. The first report produces a one-cycle wake pulse. The mode comes only from the mode input, so a wake on the bus never changes it.

Top module: `wkrx_path`

## Requirements
- R1: While reset is asserted and immediately after its release, `rx_n_o` is 1 (recessive) and `wake_o` is 0.
- R2: In mode codes 2'b11 (normal), 2'b10 (wake-call) and 2'b01 (high-speed, outside a blanking window), `rx_n_o` settles to the inverse of `bus_hi_i`: 0 while the bus is above the ordinary level and 1 otherwise.
- R3: In mode code 2'b00 (sleep), `bus_hi_i` has no effect, and `rx_n_o` stays 1 unless a qualified wake-up is being reported.
- R4: In sleep, a `bus_wk_i` level that lasts fewer than `DEAD_TICKS` filtered cycles neither drives `rx_n_o` low nor raises `wake_o`.
- R5: In sleep, a `bus_wk_i` level that lasts `DEAD_TICKS` filtered cycles is reported. `wake_o` pulses high for exactly one cycle, and `rx_n_o` goes 0 on the next cycle.
- R6: Once a wake-up has been reported in sleep, `rx_n_o` stays 0 for at least `MINP_TICKS` cycles, even if `bus_wk_i` drops at once.
- R7: In high-speed mode, a one-cycle `bus_fall_i` pulse opens a window of `BLANK_TICKS` cycles. During the window `rx_n_o` is 1 whatever `bus_hi_i` does. After the window, R2 applies again.
- R8: In normal mode, `bus_fall_i` has no effect. `rx_n_o` keeps following `bus_hi_i`.
- R9: When a reported wake-up ends in sleep, the block stays in sleep behaviour. A later ordinary-level bus activity still leaves `rx_n_o` at 1.
- R10: A comparator flag that holds its new value for a single clock cycle is rejected by the majority filter and does not reach `rx_n_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all timing windows are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Operating mode: 00 sleep, 01 high-speed, 10 wake-call, 11 normal |
| bus_hi_i | input | 1 | Asynchronous flag: bus above ordinary receive level |
| bus_wk_i | input | 1 | Asynchronous flag: bus above wake-up level |
| bus_fall_i | input | 1 | Synchronous one-cycle pulse on a dominant-to-recessive bus transition |
| rx_n_o | output | 1 | Receive data, low when the bus is reported dominant |
| wake_o | output | 1 | One-cycle pulse when a qualified wake-up is first reported |

## Verification
The properties assume three things about the inputs. The mode input changes only between scenarios, never in the middle of a wake qualification or a blanking window. `bus_fall_i` is a clean one-cycle pulse in the block's own clock domain. Each comparator flag holds its level for many cycles, except where a deliberate one-cycle glitch is under test. The stimulus respects all three by driving every input on the falling clock edge, by pausing for the filter latency after each change, and by sampling `rx_n_o` at points well inside or well outside the dead-time, minimum-pulse and blanking windows, so the filter's few cycles of delay cannot move a verdict.

// File: rtl/wkrx_pkg.sv
package wkrx_pkg;

    typedef enum logic [1:0] {
        MD_SLEEP = 2'b00,
        MD_FAST  = 2'b01,
        MD_WCALL = 2'b10,
        MD_NORM  = 2'b11
    } wkrx_mode_e;

    typedef enum logic [1:0] {
        WQ_IDLE   = 2'b00,
        WQ_COUNT  = 2'b01,
        WQ_REPORT = 2'b10
    } wq_state_e;

endpackage

// File: rtl/wkrx_sync_filt.sv
module wkrx_sync_filt #(
    parameter int CH   = 2,
    parameter int TAPS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CH-1:0] raw_i,
    output logic [CH-1:0] filt_o
);
    localparam int HALF = TAPS / 2;

    typedef struct packed {
        logic [CH-1:0]            s1;
        logic [CH-1:0]            s2;
        logic [CH-1:0][TAPS-1:0]  tap;
        logic [CH-1:0]            out;
    } filt_t;

    filt_t         q, d;
    logic [CH-1:0] vote;

    for (genvar c = 0; c < CH; c++) begin : g_ch
        assign vote[c] = ($countones(q.tap[c]) > HALF);
    end

    always_comb begin
        d     = q;
        d.s1  = raw_i;
        d.s2  = q.s1;
        for (int c = 0; c < CH; c++) begin
            d.tap[c] = {q.tap[c][TAPS-2:0], q.s2[c]};
        end
        d.out = vote;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign filt_o = q.out;
endmodule

// File: rtl/wkrx_wake_qual.sv
module wkrx_wake_qual
    import wkrx_pkg::*;
#(
    parameter int DEAD_TICKS = 1050,
    parameter int MINP_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic wk_i,
    output logic report_o,
    output logic wake_o
);
    localparam int DW = $clog2(DEAD_TICKS + 1);
    localparam int MW = $clog2(MINP_TICKS + 1);
    localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_TICKS - 1);
    localparam logic [MW-1:0] MINP_END  = MW'(MINP_TICKS);

    typedef struct packed {
        wq_state_e     st;
        logic [DW-1:0] cnt;
        logic [MW-1:0] hold;
        logic          wake;
    } qual_t;

    localparam qual_t QUAL_RST = '{st: WQ_IDLE, cnt: '0, hold: '0, wake: 1'b0};

    qual_t q, d;

    always_comb begin
        d      = q;
        d.wake = 1'b0;
        if (!en_i) begin
            d = QUAL_RST;
        end else begin
            unique case (q.st)
                WQ_IDLE: begin
                    if (wk_i) begin
                        d.st  = WQ_COUNT;
                        d.cnt = DW'(1);
                    end
                end
                WQ_COUNT: begin
                    if (!wk_i) begin
                        d.st  = WQ_IDLE;
                        d.cnt = '0;
                    end else if (q.cnt >= DEAD_LAST) begin
                        d.st   = WQ_REPORT;
                        d.cnt  = '0;
                        d.hold = '0;
                        d.wake = 1'b1;
                    end else begin
                        d.cnt = q.cnt + DW'(1);
                    end
                end
                WQ_REPORT: begin
                    if (q.hold != MINP_END) begin
                        d.hold = q.hold + MW'(1);
                    end else if (!wk_i) begin
                        d.st   = WQ_IDLE;
                        d.hold = '0;
                    end
                end
                default: d = QUAL_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= QUAL_RST;
        else        q <= d;
    end

    assign report_o = (q.st == WQ_REPORT);
    assign wake_o   = q.wake;
endmodule

// File: rtl/wkrx_blank.sv
module wkrx_blank #(
    parameter int BLANK_TICKS = 150
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic fall_i,
    output logic busy_o
);
    localparam int BW = $clog2(BLANK_TICKS + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } blank_t;

    blank_t q, d;

    always_comb begin
        d = q;
        if (!en_i)              d.cnt = '0;
        else if (fall_i)        d.cnt = BW'(BLANK_TICKS);
        else if (q.cnt != '0)   d.cnt = q.cnt - BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.cnt != '0);
endmodule

// File: rtl/wkrx_path.sv
module wkrx_path
    import wkrx_pkg::*;
#(
    parameter int DEAD_TICKS  = 1050,
    parameter int MINP_TICKS  = 250,
    parameter int BLANK_TICKS = 150,
    parameter int FILT_TAPS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       bus_hi_i,
    input  logic       bus_wk_i,
    input  logic       bus_fall_i,
    output logic       rx_n_o,
    output logic       wake_o
);
    localparam int N_FLAGS = 2;
    localparam int IDX_HI  = 0;
    localparam int IDX_WK  = 1;

    wkrx_mode_e         md;
    logic [N_FLAGS-1:0] flags_f;
    logic               wq_report;
    logic               bl_busy;

    assign md = wkrx_mode_e'(mode_i);

    wkrx_sync_filt #(.CH(N_FLAGS), .TAPS(FILT_TAPS)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({bus_wk_i, bus_hi_i}),
        .filt_o (flags_f)
    );

    wkrx_wake_qual #(.DEAD_TICKS(DEAD_TICKS), .MINP_TICKS(MINP_TICKS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (md == MD_SLEEP),
        .wk_i     (flags_f[IDX_WK]),
        .report_o (wq_report),
        .wake_o   (wake_o)
    );

    wkrx_blank #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (md == MD_FAST),
        .fall_i (bus_fall_i),
        .busy_o (bl_busy)
    );

    typedef struct packed {
        logic rx_n;
    } out_t;

    out_t q, d;

    always_comb begin
        d = q;
        unique case (md)
            MD_SLEEP: d.rx_n = ~wq_report;
            MD_FAST:  d.rx_n = bl_busy ? 1'b1 : ~flags_f[IDX_HI];
            default:  d.rx_n = ~flags_f[IDX_HI];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rx_n: 1'b1};
        else        q <= d;
    end

    assign rx_n_o = q.rx_n;
endmodule

// File: rtl/wkrx_chk.sv
module wkrx_chk
    import wkrx_pkg::*;
#(
    parameter int MINP_TICKS = 250
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       rx_n_o,
    input logic       wake_o,
    input logic       report,
    input logic       busy
);
    localparam int CW = $clog2(MINP_TICKS + 2);
    localparam logic [CW-1:0] CSAT = CW'(MINP_TICKS + 1);

    logic [CW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  low_run <= '0;
        else if (mode_i != MD_SLEEP || rx_n_o)       low_run <= '0;
        else if (low_run != CSAT)                    low_run <= low_run + CW'(1);
    end

    AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);                                        // R5
    AST_WAKE_SLEEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ($past(mode_i) == MD_SLEEP));                     // R5
    AST_WAKE_DRIVES_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && mode_i == MD_SLEEP) |=> !rx_n_o);                 // R5
    AST_SLEEP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_SLEEP && !report) |=> rx_n_o);                 // R3
    AST_BLANK_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_FAST && busy) |=> rx_n_o);                     // R7
    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MD_SLEEP && $past(mode_i) == MD_SLEEP &&
         $past(mode_i, 2) == MD_SLEEP && $rose(rx_n_o))
        |-> (low_run >= CW'(MINP_TICKS)));                           // R6
endmodule

bind wkrx_path wkrx_chk #(.MINP_TICKS(MINP_TICKS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .rx_n_o (rx_n_o),
    .wake_o (wake_o),
    .report (wq_report),
    .busy   (bl_busy)
);

// File: tb/tb_wkrx_path.sv
module tb_wkrx_path;
    localparam int DEAD  = 1050;
    localparam int MINP  = 250;
    localparam int BLANK = 150;
    localparam logic [1:0] M_SLEEP = 2'b00, M_FAST = 2'b01,
                           M_WCALL = 2'b10, M_NORM = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = M_NORM;
    logic       hi = 1'b0, wk = 1'b0, fall = 1'b0;
    logic       rx_n, wake;
    int         checks = 0, errors = 0, wake_cnt = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    wkrx_path #(.DEAD_TICKS(DEAD), .MINP_TICKS(MINP),
                .BLANK_TICKS(BLANK), .FILT_TAPS(3)) dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bus_hi_i(hi),
        .bus_wk_i(wk), .bus_fall_i(fall), .rx_n_o(rx_n), .wake_o(wake));

    always @(negedge clk) if (wake === 1'b1) wake_cnt++;

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold_rx(string req, logic exp, int n);
        logic seen = exp;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (rx_n !== exp) seen = rx_n;
        end
        chk(req, seen, exp);
    endtask

    task automatic t_reset();
        step(2);
        chk("R1 rx_n in reset", rx_n, 1'b1);
        chk("R1 wake in reset", wake, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R1 rx_n after release", rx_n, 1'b1);
    endtask

    task automatic t_active(logic [1:0] m, string tag);
        mode = m; hi = 1'b0; step(12);
        hi = 1'b1; step(12);
        chk({"R2 dominant ", tag}, rx_n, 1'b0);
        hi = 1'b0; step(12);
        chk({"R2 recessive ", tag}, rx_n, 1'b1);
    endtask

    task automatic t_glitch();
        mode = M_NORM; hi = 1'b0; step(12);
        hi = 1'b1; step(1); hi = 1'b0;
        hold_rx("R10 single-cycle glitch rejected", 1'b1, 15);
    endtask

    task automatic t_sleep_ignore();
        mode = M_SLEEP; hi = 1'b0; wk = 1'b0; step(12);
        hi = 1'b1;
        hold_rx("R3 ordinary level ignored in sleep", 1'b1, 100);
        hi = 1'b0; step(12);
    endtask

    task automatic t_short_wake();
        int w0;
        mode = M_SLEEP; step(12);
        w0 = wake_cnt;
        hi = 1'b1; wk = 1'b1;
        hold_rx("R4 short wake level not reported", 1'b1, DEAD - 100);
        hi = 1'b0; wk = 1'b0;
        hold_rx("R4 no report after short pulse", 1'b1, 150);
        chk_int("R4 no wake pulse", wake_cnt - w0, 0);
    endtask

    task automatic t_wake();
        int w0, n;
        mode = M_SLEEP; step(12);
        w0 = wake_cnt;
        hi = 1'b1; wk = 1'b1;
        step(DEAD - 20);
        chk("R5 not yet reported before dead time", rx_n, 1'b1);
        n = 0;
        while (rx_n !== 1'b0 && n < 100) begin step(1); n++; end
        chk("R5 reported after dead time", rx_n, 1'b0);
        hi = 1'b0; wk = 1'b0;
        step(MINP - 20);
        chk("R6 still low inside minimum pulse", rx_n, 1'b0);
        step(50);
        chk("R6 released after minimum pulse", rx_n, 1'b1);
        chk_int("R5 exactly one wake pulse", wake_cnt - w0, 1);
        hi = 1'b1;
        hold_rx("R9 remains in sleep behaviour", 1'b1, 60);
        hi = 1'b0; step(12);
    endtask

    task automatic t_blank();
        mode = M_FAST; hi = 1'b1; step(12);
        chk("R2 high-speed dominant before edge", rx_n, 1'b0);
        hi = 1'b0; fall = 1'b1; step(1); fall = 1'b0;
        step(20);
        hi = 1'b1;
        hold_rx("R7 blanked despite ringing", 1'b1, BLANK - 40);
        step(60);
        chk("R7 follows bus after window", rx_n, 1'b0);
        hi = 1'b0; step(12);
    endtask

    task automatic t_no_blank_normal();
        mode = M_NORM; hi = 1'b0; step(12);
        fall = 1'b1; step(1); fall = 1'b0;
        step(20);
        hi = 1'b1; step(30);
        chk("R8 falling-edge pulse ignored in normal mode", rx_n, 1'b0);
        hi = 1'b0; step(12);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_active(M_NORM,  "normal");
        t_active(M_WCALL, "wake-call");
        t_active(M_FAST,  "high-speed");
        t_glitch();
        t_sleep_ignore();
        t_short_wake();
        t_wake();
        t_blank();
        t_no_blank_normal();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule